// File: doc/BRIEF.md
# Privileged Segment Base Swap Unit

This block keeps two 64-bit segment base registers for one core: the active base, which address generation uses, and a shadow base, which holds the base the kernel wants. A decoded three-byte swap instruction exchanges the two registers in a single clock edge. An operating-system entry path can then reach kernel data through the active base without first saving any general-purpose register or touching memory.

Before any swap, the unit runs a layered fault check. Illegal-instruction conditions come first: wrong execution mode, the fast event-delivery scheme enabled, or a lock prefix. The privilege check comes after them. A separate configuration-register port gives privileged software read and write access to the shadow base. That port accepts only canonical addresses. Every accepted operation gives a one-cycle completion pulse, with at most one fault line beside it. A faulted operation changes no register.

Top module: `segbase_swap_unit`

## Requirements
- R1: After reset both base registers read zero, and `done`, `undef_fault` and `prot_fault` are low.
- R2: An instruction is recognised only when `instr_bytes[7:0]`=0x0F, `instr_bytes[15:8]`=0x01 and `instr_bytes[23:16]`=0xF8. Any other byte pattern gives no `done`, no fault and no register change.
- R3: A recognised instruction raises `undef_fault` when `mode_long64` is 0, when `evt_deliv_en` is 1, or when `instr_lock` is 1. Neither register changes.
- R4: When no R3 condition holds, a recognised instruction with `cpl` not equal to 0 raises `prot_fault` (error code zero) and changes no register. When both kinds of condition hold, only `undef_fault` is raised.
- R5: A recognised instruction with no fault makes `seg_base` take the old shadow value and the shadow take the old `seg_base`, both at the edge that samples the request. `done` is high in the following cycle.
- R6: A read on the configuration port (`cfg_write`=0) at address 0xC0000102 with `cpl`=0 returns the full 64-bit shadow value on `cfg_rdata`, with `done`, one cycle after the request.
- R7: A write at address 0xC0000102 with `cpl`=0 loads the shadow when bits 63 down to 47 of `cfg_wdata` are all equal. Otherwise it raises `prot_fault` and leaves the shadow unchanged.
- R8: A configuration access at address 0xC0000102 with `cpl` not equal to 0 raises `prot_fault`. It changes neither the shadow nor `cfg_rdata`.
- R9: At most one fault line is high in any cycle. A fault line is high only together with `done`. `done` lasts one cycle per request.
- R10: A configuration access in the same cycle as a recognised instruction is ignored. An access to any other address gives no `done`, no fault and no change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Decoded instruction strobe |
| instr_bytes | input | 24 | Opcode bytes, first byte in bits 7:0 |
| instr_lock | input | 1 | Lock prefix present |
| mode_long64 | input | 1 | Code segment is in 64-bit mode |
| evt_deliv_en | input | 1 | Fast event-delivery scheme enabled |
| cpl | input | 2 | Current privilege level |
| cfg_valid | input | 1 | Configuration access strobe |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 32 | Configuration register address |
| cfg_wdata | input | 64 | Write data |
| seg_base | output | 64 | Active segment base |
| cfg_rdata | output | 64 | Read data of the last accepted read |
| done | output | 1 | Completion pulse |
| undef_fault | output | 1 | Illegal-instruction fault |
| prot_fault | output | 1 | Protection fault, error code zero |

## Verification
The swap is run twice in a row with two different shadow values. This shows a true exchange apart from a one-way copy, and a swap that runs again apart from one that runs only once. Each fault cause is applied alone, and then together with a non-zero privilege level, so the illegal-instruction check is shown to take precedence over the privilege check. Opcode patterns that differ in one byte, or that have the right bytes in the wrong order, show that all three byte lanes are decoded. Configuration writes use values on both sides of the bit-47 boundary, and accesses are made at wrong privilege levels, at a wrong address, and in the same cycle as a swap. These separate the canonical check, the privilege gate, the address match and the arbitration with the instruction path.

// File: rtl/segswap_pkg.sv
// Package segswap_pkg
// Holds the constants and types shared by the segment base swap unit:
// the opcode byte values, the address of the shadow register, and the
// fault classification. Assumes opcode bytes arrive first byte lowest.
package segswap_pkg;

    localparam int OPC_LEN = 3;
    localparam logic [7:0] OPC_BYTE0 = 8'h0F;
    localparam logic [7:0] OPC_BYTE1 = 8'h01;
    localparam logic [7:0] OPC_BYTE2 = 8'hF8;

    localparam logic [31:0] SHADOW_CFG_ADDR = 32'hC000_0102;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_UNDEF = 2'd1,
        FLT_PROT  = 2'd2
    } fault_e;

    // Expected opcode byte for a lane index.
    function automatic logic [7:0] opc_byte(input int idx);
        case (idx)
            0:       return OPC_BYTE0;
            1:       return OPC_BYTE1;
            default: return OPC_BYTE2;
        endcase
    endfunction

endpackage

// File: rtl/swap_fault_check.sv
// Module swap_fault_check
// Decodes the swap opcode and classifies the request.
// Mode, event-delivery and lock-prefix conditions give an
// illegal-instruction fault. The privilege check comes after them.
// Purely combinational. Assumes the caller registers the results.
module swap_fault_check
    import segswap_pkg::*;
#(
    parameter int PRIV_W = 2
) (
    input  logic                 instr_valid,
    input  logic [OPC_LEN*8-1:0] instr_bytes,
    input  logic                 instr_lock,
    input  logic                 mode_long64,
    input  logic                 evt_deliv_en,
    input  logic [PRIV_W-1:0]    cpl,
    output logic                 instr_hit,
    output fault_e               instr_fault,
    output logic                 swap_go
);

    logic [OPC_LEN-1:0] lane_ok;

    // One comparator per opcode byte lane.
    for (genvar gi = 0; gi < OPC_LEN; gi++) begin : g_lane
        assign lane_ok[gi] = (instr_bytes[gi*8 +: 8] == opc_byte(gi));
    end

    // Recognition and the layered fault classification.
    always_comb begin
        instr_hit = instr_valid && (&lane_ok);
        if (!mode_long64 || evt_deliv_en || instr_lock) begin
            instr_fault = FLT_UNDEF;
        end else if (cpl != '0) begin
            instr_fault = FLT_PROT;
        end else begin
            instr_fault = FLT_NONE;
        end
        swap_go = instr_hit && (instr_fault == FLT_NONE);
    end

endmodule

// File: rtl/cfg_access_check.sv
// Module cfg_access_check
// Matches configuration accesses to the shadow base register, gates
// them on privilege level zero, and rejects non-canonical write data.
// An address is canonical when bits DATA_W-1 down to VA_BITS-1 all
// match. Assumes an instruction in the same cycle wins (cfg_block).
module cfg_access_check
    import segswap_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 64,
    parameter int VA_BITS = 48,
    parameter int PRIV_W  = 2
) (
    input  logic              cfg_valid,
    input  logic              cfg_write,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [PRIV_W-1:0] cpl,
    input  logic              cfg_block,
    output logic              cfg_hit,
    output fault_e            cfg_fault,
    output logic              wr_go,
    output logic              rd_go
);

    localparam int UPPER_W = DATA_W - VA_BITS + 1;

    logic [UPPER_W-1:0] upper_bits;
    logic               canonical;

    assign upper_bits = cfg_wdata[DATA_W-1:VA_BITS-1];

    // Canonical form: the upper bits are all ones or all zeros.
    always_comb begin
        canonical = (&upper_bits) || !(|upper_bits);
    end

    // Address match, privilege gate and data check.
    always_comb begin
        cfg_hit = cfg_valid && !cfg_block &&
                  (cfg_addr == SHADOW_CFG_ADDR[ADDR_W-1:0]);
        if (cpl != '0) begin
            cfg_fault = FLT_PROT;
        end else if (cfg_write && !canonical) begin
            cfg_fault = FLT_PROT;
        end else begin
            cfg_fault = FLT_NONE;
        end
        wr_go = cfg_hit && cfg_write  && (cfg_fault == FLT_NONE);
        rd_go = cfg_hit && !cfg_write && (cfg_fault == FLT_NONE);
    end

endmodule

// File: rtl/base_pair_regs.sv
// Module base_pair_regs
// Holds the active and shadow base registers. A swap exchanges them
// at one edge. A configuration write loads the shadow only.
// Assumes swap_go and wr_go are never high together (the caller
// arbitrates). Synchronous active-low reset clears both registers.
module base_pair_regs #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              swap_go,
    input  logic              wr_go,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] active_q,
    output logic [DATA_W-1:0] shadow_q
);

    // Register update: reset, exchange, or shadow load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '0;
            shadow_q <= '0;
        end else if (swap_go) begin
            active_q <= shadow_q;
            shadow_q <= active_q;
        end else if (wr_go) begin
            shadow_q <= wr_data;
        end
    end

    AST_SWAP_EXCHANGES: assert property (@(posedge clk) disable iff (!rst_n)
        swap_go |=> (active_q == $past(shadow_q)) && (shadow_q == $past(active_q))); // R5

    AST_WRITE_LOADS_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> (shadow_q == $past(wr_data)) && $stable(active_q)); // R7

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!swap_go && !wr_go) |=> $stable(active_q) && $stable(shadow_q)); // R8

endmodule

// File: rtl/segbase_swap_unit.sv
// Module segbase_swap_unit
// Top of the segment base swap unit. It joins the instruction fault
// check, the configuration access check and the register pair, and
// registers the completion, fault and read-data outputs one cycle
// after the request. Assumes the inputs are synchronous to clk.
module segbase_swap_unit
    import segswap_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int ADDR_W  = 32,
    parameter int VA_BITS = 48,
    parameter int PRIV_W  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 instr_valid,
    input  logic [OPC_LEN*8-1:0] instr_bytes,
    input  logic                 instr_lock,
    input  logic                 mode_long64,
    input  logic                 evt_deliv_en,
    input  logic [PRIV_W-1:0]    cpl,
    input  logic                 cfg_valid,
    input  logic                 cfg_write,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [DATA_W-1:0]    cfg_wdata,
    output logic [DATA_W-1:0]    seg_base,
    output logic [DATA_W-1:0]    cfg_rdata,
    output logic                 done,
    output logic                 undef_fault,
    output logic                 prot_fault
);

    logic        instr_hit;
    fault_e      instr_fault;
    logic        swap_go;
    logic        cfg_hit;
    fault_e      cfg_fault;
    logic        wr_go;
    logic        rd_go;
    fault_e      op_fault;
    logic        op_hit;
    logic [DATA_W-1:0] shadow_q;

    swap_fault_check #(.PRIV_W(PRIV_W)) u_fault (
        .instr_valid  (instr_valid),
        .instr_bytes  (instr_bytes),
        .instr_lock   (instr_lock),
        .mode_long64  (mode_long64),
        .evt_deliv_en (evt_deliv_en),
        .cpl          (cpl),
        .instr_hit    (instr_hit),
        .instr_fault  (instr_fault),
        .swap_go      (swap_go)
    );

    cfg_access_check #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .VA_BITS (VA_BITS),
        .PRIV_W  (PRIV_W)
    ) u_cfg (
        .cfg_valid (cfg_valid),
        .cfg_write (cfg_write),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cpl       (cpl),
        .cfg_block (instr_hit),
        .cfg_hit   (cfg_hit),
        .cfg_fault (cfg_fault),
        .wr_go     (wr_go),
        .rd_go     (rd_go)
    );

    base_pair_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .swap_go  (swap_go),
        .wr_go    (wr_go),
        .wr_data  (cfg_wdata),
        .active_q (seg_base),
        .shadow_q (shadow_q)
    );

    // Select the fault of whichever operation was accepted this cycle.
    always_comb begin
        op_hit   = instr_hit || cfg_hit;
        op_fault = instr_hit ? instr_fault : (cfg_hit ? cfg_fault : FLT_NONE);
    end

    // Register the completion and fault outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done        <= 1'b0;
            undef_fault <= 1'b0;
            prot_fault  <= 1'b0;
        end else begin
            done        <= op_hit;
            undef_fault <= op_hit && (op_fault == FLT_UNDEF);
            prot_fault  <= op_hit && (op_fault == FLT_PROT);
        end
    end

    // Capture the shadow value on an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_rdata <= '0;
        end else if (rd_go) begin
            cfg_rdata <= shadow_q;
        end
    end

    AST_ONE_FAULT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({undef_fault, prot_fault})); // R9

    AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (undef_fault || prot_fault) |-> done); // R9

    AST_FAULT_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (undef_fault || prot_fault) |-> $stable(seg_base) && $stable(shadow_q)); // R3

    AST_UNDEF_BEATS_PROT: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_hit && !mode_long64 && (cpl != '0)) |=> undef_fault && !prot_fault); // R4

    AST_BAD_OPCODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !instr_hit && !cfg_valid) |=> !done && $stable(seg_base)); // R2

    AST_LOW_PRIV_CFG_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_hit && (cpl != '0)) |=> prot_fault && $stable(cfg_rdata)); // R8

endmodule

// File: tb/segbase_swap_unit_tb.sv
`timescale 1ns/1ps
// Directed bench for segbase_swap_unit: one task per scenario.
module segbase_swap_unit_tb;

    localparam logic [23:0] OPC_OK   = 24'hF8_01_0F;
    localparam logic [31:0] SH_ADDR  = 32'hC000_0102;
    localparam logic [63:0] K1 = 64'hFFFF_8000_0000_1000;
    localparam logic [63:0] K2 = 64'h0000_7FFF_FFFF_F000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [23:0] instr_bytes = '0;
    logic        instr_lock = 1'b0;
    logic        mode_long64 = 1'b1;
    logic        evt_deliv_en = 1'b0;
    logic [1:0]  cpl = '0;
    logic        cfg_valid = 1'b0;
    logic        cfg_write = 1'b0;
    logic [31:0] cfg_addr = '0;
    logic [63:0] cfg_wdata = '0;
    logic [63:0] seg_base;
    logic [63:0] cfg_rdata;
    logic        done;
    logic        undef_fault;
    logic        prot_fault;

    int n_checks = 0;
    int n_fails  = 0;
    logic [63:0] exp_act = '0;
    logic [63:0] exp_shd = '0;

    always #2 clk = ~clk;

    segbase_swap_unit u_dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid),
        .instr_bytes(instr_bytes), .instr_lock(instr_lock),
        .mode_long64(mode_long64), .evt_deliv_en(evt_deliv_en), .cpl(cpl),
        .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .seg_base(seg_base), .cfg_rdata(cfg_rdata),
        .done(done), .undef_fault(undef_fault), .prot_fault(prot_fault)
    );

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Flags packed as {done, undef_fault, prot_fault}.
    task automatic check_flags(input logic [2:0] exp, input string tag);
        check({61'd0, done, undef_fault, prot_fault}, {61'd0, exp}, tag);
    endtask

    task automatic run_instr(input logic [23:0] b, input logic lk, input logic m64,
                             input logic ev, input logic [1:0] pl);
        @(negedge clk);
        instr_valid = 1'b1; instr_bytes = b; instr_lock = lk;
        mode_long64 = m64; evt_deliv_en = ev; cpl = pl;
        @(negedge clk);
        instr_valid = 1'b0; instr_lock = 1'b0; mode_long64 = 1'b1;
        evt_deliv_en = 1'b0; cpl = '0;
    endtask

    task automatic run_cfg(input logic wr, input logic [31:0] a,
                           input logic [63:0] d, input logic [1:0] pl);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_write = wr; cfg_addr = a; cfg_wdata = d; cpl = pl;
        @(negedge clk);
        cfg_valid = 1'b0; cfg_write = 1'b0; cpl = '0;
    endtask

    // Read the shadow at privilege 0 and compare with the model.
    task automatic read_shadow(input string tag);
        run_cfg(1'b0, SH_ADDR, '0, 2'd0);
        check_flags(3'b100, {tag, " read flags"});
        check(cfg_rdata, exp_shd, {tag, " shadow"});
    endtask

    task automatic t_reset;
        check(seg_base, '0, "R1 seg_base after reset");
        check_flags(3'b000, "R1 flags after reset");
        read_shadow("R1");
    endtask

    task automatic t_swap_twice;
        run_cfg(1'b1, SH_ADDR, K1, 2'd0); exp_shd = K1;
        check_flags(3'b100, "R7 canonical write K1");
        read_shadow("R6 R7");
        run_instr(OPC_OK, 0, 1, 0, 2'd0);
        exp_act = K1; exp_shd = 64'd0;
        check_flags(3'b100, "R5 swap flags");
        check(seg_base, exp_act, "R5 first swap seg_base");
        @(negedge clk);
        check_flags(3'b000, "R9 done lasts one cycle");
        read_shadow("R5 first swap");
        run_cfg(1'b1, SH_ADDR, K2, 2'd0); exp_shd = K2;
        run_instr(OPC_OK, 0, 1, 0, 2'd0);
        exp_act = K2; exp_shd = K1;
        check(seg_base, exp_act, "R5 second swap seg_base");
        read_shadow("R5 second swap");
    endtask

    task automatic t_faults;
        run_instr(OPC_OK, 0, 0, 0, 2'd0);
        check_flags(3'b110, "R3 not 64-bit mode");
        check(seg_base, exp_act, "R3 seg_base kept (mode)");
        run_instr(OPC_OK, 0, 1, 1, 2'd0);
        check_flags(3'b110, "R3 event delivery enabled");
        run_instr(OPC_OK, 1, 1, 0, 2'd0);
        check_flags(3'b110, "R3 lock prefix");
        run_instr(OPC_OK, 0, 1, 0, 2'd3);
        check_flags(3'b101, "R4 cpl 3");
        check(seg_base, exp_act, "R4 seg_base kept");
        run_instr(OPC_OK, 0, 0, 0, 2'd1);
        check_flags(3'b110, "R4 undef wins over prot");
        read_shadow("R3 R4 shadow kept");
    endtask

    task automatic t_bad_opcode;
        run_instr(24'hF9_01_0F, 0, 1, 0, 2'd0);
        check_flags(3'b000, "R2 last byte wrong");
        run_instr(24'h0F_01_F8, 0, 1, 0, 2'd0);
        check_flags(3'b000, "R2 reversed byte order");
        run_instr(24'hF8_00_0F, 0, 1, 0, 2'd0);
        check_flags(3'b000, "R2 middle byte wrong");
        check(seg_base, exp_act, "R2 seg_base kept");
        read_shadow("R2 shadow kept");
    endtask

    task automatic t_cfg_rules;
        logic [63:0] last_rd;
        run_cfg(1'b1, SH_ADDR, 64'h0000_8000_0000_0000, 2'd0);
        check_flags(3'b101, "R7 bit 47 alone non-canonical");
        run_cfg(1'b1, SH_ADDR, 64'h8000_0000_0000_0000, 2'd0);
        check_flags(3'b101, "R7 bit 63 alone non-canonical");
        read_shadow("R7 shadow kept");
        last_rd = cfg_rdata;
        run_cfg(1'b0, SH_ADDR, '0, 2'd1);
        check_flags(3'b101, "R8 read at cpl 1");
        check(cfg_rdata, last_rd, "R8 rdata unchanged");
        run_cfg(1'b1, SH_ADDR, K2, 2'd3);
        check_flags(3'b101, "R8 write at cpl 3");
        read_shadow("R8 shadow kept");
        run_cfg(1'b1, 32'hC000_0101, K2, 2'd0);
        check_flags(3'b000, "R10 other address ignored");
        read_shadow("R10 shadow kept");
    endtask

    task automatic t_collision;
        @(negedge clk);
        instr_valid = 1'b1; instr_bytes = OPC_OK;
        cfg_valid = 1'b1; cfg_write = 1'b1; cfg_addr = SH_ADDR; cfg_wdata = 64'h1234;
        @(negedge clk);
        instr_valid = 1'b0; cfg_valid = 1'b0; cfg_write = 1'b0;
        exp_act = K1; exp_shd = K2;
        check_flags(3'b100, "R10 collision single done");
        check(seg_base, exp_act, "R10 swap wins");
        read_shadow("R10 write dropped");
    endtask

    initial begin
        #(200000 * 4);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_swap_twice();
        t_faults();
        t_bad_opcode();
        t_cfg_rules();
        t_collision();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule